// File: doc/BRIEF.md
# Two-Word Absolute Jump Unit

This block sits in the fetch path of a small controller with 8-bit data. It watches a stream of 16-bit program words and keeps a 21-bit byte-addressed program counter. While fetch is sequential, the counter moves forward by two bytes for every word that is accepted. When the unit sees the opening word of the unconditional absolute jump, it saves the low eight bits of the target. The next accepted word must carry the continuation prefix. That word supplies target bits 19:8, and the unit then writes the full 20-bit literal into counter bits 20:1. Bit 0 stays at zero because instructions are word-aligned.

The second cycle of a jump does no work of its own. The unit marks it with a one-cycle flush pulse, so the surrounding pipeline can drop whatever it fetched sequentially. The jump changes no status flags and no other state.

A word can follow an opening word without the continuation prefix. In that case the unit raises an illegal flag for one cycle, drops the half-built jump and continues fetching in sequence. While the unit waits for the second word, that word is never decoded as the start of a new instruction.

Top module: `abs_jump_unit`

## Requirements
- R1: After reset the counter is 0, both flags are low and no jump is pending, so a continuation-prefixed word that follows reset is treated as an ordinary word.
- R2: An accepted word that neither opens nor completes a jump advances the counter by 2, modulo 2^21. For example, 0x1FFFFE wraps to 0.
- R3: A cycle with the valid strobe low leaves the counter unchanged and both flags low.
- R4: An accepted word with no jump pending whose bits 15:8 equal 0xEF opens a jump. The counter advances by 2, both flags stay low, and bits 7:0 become target bits 7:0.
- R5: With a jump pending, an accepted word whose bits 15:12 equal 0xF completes it. On the next cycle the counter equals {word[11:0], saved low byte, 1'b0}.
- R6: The flush output is high for exactly the one cycle in which the counter shows the loaded target. It is never high together with the illegal flag.
- R7: With a jump pending, an accepted word whose bits 15:12 differ from 0xF raises the illegal flag for one cycle. It also clears the pending jump and advances the counter by 2.
- R8: A word accepted while a jump is pending is never decoded as an opening word, even if its bits 15:8 equal 0xEF. The word after it is decoded normally.
- R9: Idle cycles between the two words of a jump keep the pending jump and its saved low byte.
- R10: Counter bit 0 is zero in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| word_i | input | 16 | Fetched program word |
| word_valid_i | input | 1 | Accepts word_i in this cycle |
| pc_o | output | 21 | Byte program counter |
| flush_o | output | 1 | Marks the no-operation second cycle of a completed jump |
| illegal_o | output | 1 | Second word of a jump lacked the continuation prefix |

## Verification
All three outputs come straight from registers. Each result is due one clock edge after the word that causes it is accepted: the counter value, the flush pulse and the illegal pulse. The bench drives each word on a falling edge and lets one rising edge pass. It compares all three outputs with its model at the next falling edge, before it drives anything else, so every comparison lands in exactly the cycle that the word affects. After reset is released, the bench waits out the two synchroniser stages before the first word.

// File: rtl/abs_jump_pkg.sv
package abs_jump_pkg;
  localparam int WORD_W     = 16;
  localparam int LO_W       = 8;
  localparam int OPEN_TAG_W = WORD_W - LO_W;
  localparam int CONT_TAG_W = 4;
  localparam logic [OPEN_TAG_W-1:0] OPEN_TAG = 8'hEF;
  localparam logic [CONT_TAG_W-1:0] CONT_TAG = 4'hF;

  typedef enum logic [1:0] {
    WORD_PLAIN = 2'd0,
    WORD_OPEN  = 2'd1,
    WORD_CONT  = 2'd2,
    WORD_BAD   = 2'd3
  } word_kind_e;
endpackage

// File: rtl/abs_jump_rst_sync.sv
module abs_jump_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/abs_jump_decode.sv
module abs_jump_decode
  import abs_jump_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              pend_i,
  output word_kind_e        kind_o
);
  logic open_hit;
  logic cont_hit;

  assign open_hit = (word_i[WORD_W-1 -: OPEN_TAG_W] == OPEN_TAG);
  assign cont_hit = (word_i[WORD_W-1 -: CONT_TAG_W] == CONT_TAG);

  always_comb begin
    if (pend_i) kind_o = cont_hit ? WORD_CONT : WORD_BAD;
    else        kind_o = open_hit ? WORD_OPEN : WORD_PLAIN;
  end
endmodule

// File: rtl/abs_jump_pc.sv
module abs_jump_pc #(
  parameter int PC_W = 21,
  localparam int LIT_W = PC_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [LIT_W-1:0] target_i,
  output logic [PC_W-1:0]  pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    if (en_i) begin
      if (load_i) pc_d = {target_i, 1'b0};
      else        pc_d = pc_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/abs_jump_unit.sv
module abs_jump_unit
  import abs_jump_pkg::*;
#(
  parameter int PC_W = 21,
  localparam int LIT_W = PC_W - 1,
  localparam int HI_W  = LIT_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              flush_o,
  output logic              illegal_o
);
  logic            rst_sync_n;
  word_kind_e      kind;
  logic            pend_q, pend_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic            flush_q, flush_d;
  logic            ill_q, ill_d;
  logic            pc_load;

  abs_jump_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  abs_jump_decode u_dec (
    .word_i(word_i), .pend_i(pend_q), .kind_o(kind)
  );

  always_comb begin
    pend_d  = pend_q;
    lo_d    = lo_q;
    flush_d = 1'b0;
    ill_d   = 1'b0;
    pc_load = 1'b0;
    if (word_valid_i) begin
      unique case (kind)
        WORD_OPEN: begin
          pend_d = 1'b1;
          lo_d   = word_i[LO_W-1:0];
        end
        WORD_CONT: begin
          pend_d  = 1'b0;
          pc_load = 1'b1;
          flush_d = 1'b1;
        end
        WORD_BAD: begin
          pend_d = 1'b0;
          ill_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q  <= 1'b0;
      lo_q    <= '0;
      flush_q <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      lo_q    <= lo_d;
      flush_q <= flush_d;
      ill_q   <= ill_d;
    end
  end

  abs_jump_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_sync_n), .en_i(word_valid_i), .load_i(pc_load),
    .target_i({word_i[HI_W-1:0], lo_q}), .pc_o(pc_o)
  );

  assign flush_o   = flush_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/abs_jump_unit_chk.sv
module abs_jump_unit_chk
  import abs_jump_pkg::*;
#(
  parameter int PC_W = 21,
  localparam int HI_W = PC_W - 1 - LO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_i,
  input logic              word_valid_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              flush_o,
  input logic              illegal_o,
  input logic              pend_q,
  input logic [LO_W-1:0]   lo_q
);
  logic cont_word;
  logic open_word;
  assign cont_word = (word_i[WORD_W-1 -: CONT_TAG_W] == CONT_TAG);
  assign open_word = (word_i[WORD_W-1 -: OPEN_TAG_W] == OPEN_TAG);

  assert_pc_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[0] == 1'b0);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_i |=> $stable(pc_o) && !flush_o && !illegal_o);

  assert_flags_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_o && illegal_o));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_i && !(pend_q && cont_word) |=> pc_o == PC_W'($past(pc_o) + 2));

  assert_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_i && !pend_q && open_word |=> pend_q && !flush_o && !illegal_o);

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_i && pend_q && cont_word
      |=> flush_o && pc_o == {$past(word_i[HI_W-1:0]), $past(lo_q), 1'b0});

  assert_bad_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_i && pend_q && !cont_word |=> illegal_o && !flush_o);

  assert_no_redecode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_i && pend_q |=> !pend_q);

  assert_wait_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_i && pend_q |=> pend_q && $stable(lo_q));
endmodule

bind abs_jump_unit abs_jump_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .word_i(word_i), .word_valid_i(word_valid_i),
  .pc_o(pc_o), .flush_o(flush_o), .illegal_o(illegal_o),
  .pend_q(pend_q), .lo_q(lo_q)
);

// File: tb/abs_jump_unit_test.sv
module abs_jump_unit_test;
  localparam int PC_W = 21;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     word_i = '0;
  logic            word_valid_i = 1'b0;
  logic [PC_W-1:0] pc_o;
  logic            flush_o, illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [PC_W-1:0] m_pc = '0;
  logic            m_pend = 1'b0;
  logic [7:0]      m_lo = '0;

  always #5 clk = ~clk;

  abs_jump_unit #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_valid_i(word_valid_i),
    .pc_o(pc_o), .flush_o(flush_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] p);
    return PC_W'(p + 2);
  endfunction

  // drive at a falling edge, pass one rising edge, compare at the next falling edge
  task automatic step(input logic v, input logic [15:0] w, input string force_tag = "");
    string tag;
    logic  e_fl, e_il;
    e_fl = 1'b0;
    e_il = 1'b0;
    word_valid_i = v;
    word_i = w;
    if (!v) begin
      tag = m_pend ? "R9" : "R3";
    end else if (m_pend && w[15:12] == 4'hF) begin
      tag = "R5";
      m_pc = {w[11:0], m_lo, 1'b0};
      m_pend = 1'b0;
      e_fl = 1'b1;
    end else if (m_pend) begin
      tag = (w[15:8] == 8'hEF) ? "R8" : "R7";
      m_pc = seq_next(m_pc);
      m_pend = 1'b0;
      e_il = 1'b1;
    end else if (w[15:8] == 8'hEF) begin
      tag = "R4";
      m_pc = seq_next(m_pc);
      m_pend = 1'b1;
      m_lo = w[7:0];
    end else begin
      tag = "R2";
      m_pc = seq_next(m_pc);
    end
    if (force_tag != "") tag = force_tag;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "pc", 32'(pc_o), 32'(m_pc));
    chk(e_fl ? "R6" : tag, "flush", 32'(flush_o), 32'(e_fl));
    chk(tag, "illegal", 32'(illegal_o), 32'(e_il));
    chk("R10", "pc bit0", 32'(pc_o[0]), 32'd0);
    word_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    word_valid_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", 32'(pc_o), 32'd0);
    chk("R1", "flush in reset", 32'(flush_o), 32'd0);
    chk("R1", "illegal in reset", 32'(illegal_o), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_pc = '0;
    m_pend = 1'b0;
    m_lo = '0;
    chk("R1", "pc after release", 32'(pc_o), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    step(1'b1, 16'h1234);
    step(1'b0, 16'hEF00);
    step(1'b1, 16'hEF55);
    step(1'b0, 16'h0000);
    step(1'b0, 16'hF999);
    step(1'b1, 16'hF123);
    chk("R5", "directed target", 32'(pc_o), 32'h246AA);

    step(1'b1, 16'hEFFF);
    step(1'b1, 16'hFFFF);
    chk("R5", "top target", 32'(pc_o), 32'h1FFFFE);
    step(1'b1, 16'h0000);
    chk("R2", "wrap", 32'(pc_o), 32'd0);

    step(1'b1, 16'hEF01);
    step(1'b1, 16'hEF02);
    step(1'b1, 16'hF0AB, "R8");
    step(1'b1, 16'hEF03);
    step(1'b1, 16'h1200);

    step(1'b1, 16'hEF10);
    do_reset();
    step(1'b1, 16'hF0AB, "R1");
    chk("R1", "no stale jump", 32'(pc_o), 32'd2);

    for (int i = 0; i < 2000; i++) begin
      logic [15:0] w;
      int sel;
      sel = int'($urandom % 8);
      w = 16'($urandom);
      if (sel < 2)       w[15:8] = 8'hEF;
      else if (sel < 4)  w[15:12] = 4'hF;
      step(sel != 4, w);
    end

    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule